// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port Block RAM

This block is a synchronous on-chip RAM with two ports. One port only writes and the other only reads. Each port has its own clock, clock enable and address. The write word width and the read word width are set by separate parameters over one shared storage array. A design can therefore store narrow items and fetch them several at a time, or store wide words and fetch them in pieces.

Two width families exist. The plain family uses widths 1, 2, 4, 8, 16 and 32 over 4096 bits. The parity family uses widths 9, 18 and 36 over 4608 bits. Port depth is always the array size divided by that port's width. Writes of 16 bits or wider can be masked per lane. Either port can freeze its address so that it keeps working on the location it last captured. The read output is a register. It changes only on an enabled read or an asynchronous clear. A read and a write to the same location on the same edge returns the contents from before the write.

Top module: `mwram_top`

## Requirements
- R1: Array size is 4096 bits for `FAMILY` plain (widths 1, 2, 4, 8, 16, 32) and 4608 bits for parity (widths 9, 18, 36). Each port addresses every word from 0 up to size/width-1, including the last one.
- R2: When the widths differ, a wide word is made of consecutive narrow words. The narrow word with the lowest address is in the least significant bits. With 16-bit writes and 8-bit reads, write word A appears at read address 2A (bits 7:0) and 2A+1 (bits 15:8).
- R3: On a read-clock edge where `rd_ce` or `rd_en` is low, `rd_q` keeps its previous value.
- R4: On a read-clock edge with `rd_ce` and `rd_en` both high, `rd_q` shows the addressed word right after that edge. The latency is one read clock.
- R5: If a read and a write hit the same location on the same edge, `rd_q` returns the data from before that write. A later read returns the new data.
- R6: For write widths of 16 or more, `wr_be` has one bit per lane. A lane is 8 bits in the plain family and 9 bits in the parity family. Bit k covers write-data bits [k*lane +: lane]. A lane whose bit is low keeps its stored value.
- R7: While `wr_stall` is high, writes go to the write address captured on the last unstalled enabled edge, and `wr_addr` is ignored.
- R8: While `rd_stall` is high, reads use the read address captured on the last unstalled enabled edge, and `rd_addr` is ignored.
- R9: No location changes on a write-clock edge where `wr_ce` or `wr_en` is low.
- R10: `rd_clr` drives `rd_q` to zero at once, without waiting for a clock. It also sets the held read address to 0. Stored contents are kept.
- R11: `wr_srst`, sampled on the write clock, sets the held write address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_srst | input | 1 | Synchronous reset of the held write address |
| wr_ce | input | 1 | Write-side clock enable |
| wr_en | input | 1 | Write request |
| wr_stall | input | 1 | Reuse the held write address |
| wr_addr | input | WA_W | Write word address |
| wr_data | input | WR_W | Write data |
| wr_be | input | BE_W | Lane enables (ignored below 16 bits) |
| rd_clk | input | 1 | Read-side clock |
| rd_clr | input | 1 | Asynchronous clear of output and held read address |
| rd_ce | input | 1 | Read-side clock enable |
| rd_en | input | 1 | Read request |
| rd_stall | input | 1 | Reuse the held read address |
| rd_addr | input | RA_W | Read word address |
| rd_q | output | RD_W | Registered read data |

## Verification
The assertions assume a few things about the inputs. `rd_clr` stays high across any read-clock edge it overlaps. Stall inputs follow a reset or clear before they are first used. The clock inputs are clean. Nothing is assumed about data or addresses. The stimulus changes inputs only one time unit after a rising edge, holds every clear and reset over full clock periods, and asserts a stall only after an unstalled enabled access has loaded the held address. Both clock inputs are tied to one 200 MHz clock, so same-edge collisions can be made on purpose.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    typedef enum logic {
        FAM_PLAIN  = 1'b0,
        FAM_PARITY = 1'b1
    } fam_e;

    function automatic int total_bits(fam_e fam);
        return (fam == FAM_PARITY) ? 4608 : 4096;
    endfunction

    function automatic int lane_bits(fam_e fam);
        return (fam == FAM_PARITY) ? 9 : 8;
    endfunction

    function automatic int be_lanes(int width, fam_e fam);
        return (width >= 16) ? width / lane_bits(fam) : 1;
    endfunction

endpackage

// File: rtl/mwram_addr_hold.sv
module mwram_addr_hold #(
    parameter int AW        = 8,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ce,
    input  logic          stall,
    input  logic [AW-1:0] a_in,
    output logic [AW-1:0] a_eff
);
    logic [AW-1:0] held;

    assign a_eff = stall ? held : a_in;

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or posedge clr) begin
                if (clr)     held <= '0;
                else if (ce) held <= a_eff;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (clr)     held <= '0;
                else if (ce) held <= a_eff;
            end
        end
    endgenerate

    // R7 / R8: a stalled enabled edge keeps the held address
    p_stall_keeps_r7_r8: assert property (@(posedge clk) disable iff (clr)
        (ce && stall) |=> (held == $past(held)));

    // R7 / R8: after an unstalled capture, a stall reuses that address
    p_stall_uses_last_r8: assert property (@(posedge clk) disable iff (clr)
        (ce && !stall) |=> (stall -> (a_eff == $past(a_in))));

endmodule

// File: rtl/mwram_lane_mask.sv
module mwram_lane_mask
    import mwram_pkg::*;
#(
    parameter fam_e FAMILY = FAM_PLAIN,
    parameter int   WR_W   = 16,
    localparam int  LANE   = lane_bits(FAMILY),
    localparam int  BE_W   = be_lanes(WR_W, FAMILY)
) (
    input  logic            go,
    input  logic [BE_W-1:0] be,
    output logic [WR_W-1:0] mask
);
    generate
        if (WR_W >= 16) begin : g_lanes
            for (genvar l = 0; l < BE_W; l++) begin : g_lane
                assign mask[l*LANE +: LANE] = {LANE{go & be[l]}};
            end
            // R6: written bit count equals enabled lanes times lane width
            always_comb begin
                if (go) begin
                    p_be_lanes_r6: assert ($countones(mask) == LANE * $countones(be));
                end
            end
        end else begin : g_whole
            logic unused_be;
            assign unused_be = ^be;
            assign mask      = {WR_W{go}};
        end
    endgenerate

endmodule

// File: rtl/mwram_array.sv
module mwram_array #(
    parameter int  MEM_BITS = 4096,
    parameter int  WR_W     = 16,
    parameter int  RD_W     = 8,
    localparam int MEM_AW   = $clog2(MEM_BITS),
    localparam int WA_W     = $clog2(MEM_BITS / WR_W),
    localparam int RA_W     = $clog2(MEM_BITS / RD_W)
) (
    input  logic            wr_clk,
    input  logic [WA_W-1:0] wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic [WR_W-1:0] wr_mask,
    input  logic            rd_clk,
    input  logic            rd_clr,
    input  logic            rd_go,
    input  logic [RA_W-1:0] rd_addr,
    output logic [RD_W-1:0] rd_q
);
    logic [MEM_BITS-1:0] mem;
    logic [MEM_AW-1:0]   wbase;
    logic [MEM_AW-1:0]   rbase;

    assign wbase = MEM_AW'(wr_addr) * MEM_AW'(WR_W);
    assign rbase = MEM_AW'(rd_addr) * MEM_AW'(RD_W);

    always_ff @(posedge wr_clk) begin
        for (int i = 0; i < WR_W; i++) begin
            if (wr_mask[i]) mem[wbase + MEM_AW'(i)] <= wr_data[i];
        end
    end

    // Nonblocking read: a same-edge write is not yet visible (old data)
    always_ff @(posedge rd_clk or posedge rd_clr) begin
        if (rd_clr)     rd_q <= '0;
        else if (rd_go) rd_q <= mem[rbase +: RD_W];
    end

    // R3: output holds across an edge without an enabled read
    p_hold_r3: assert property (@(posedge rd_clk) disable iff (rd_clr)
        !rd_go |=> $stable(rd_q));

    // R10: clear forces the output to zero (this check is about the clear itself)
    p_clear_zero_r10: assert property (@(posedge rd_clk)
        rd_clr |-> (rd_q == '0));

endmodule

// File: rtl/mwram_top.sv
module mwram_top
    import mwram_pkg::*;
#(
    parameter fam_e FAMILY   = FAM_PLAIN,
    parameter int   WR_W     = 16,
    parameter int   RD_W     = 8,
    localparam int  MEM_BITS = total_bits(FAMILY),
    localparam int  WA_W     = $clog2(MEM_BITS / WR_W),
    localparam int  RA_W     = $clog2(MEM_BITS / RD_W),
    localparam int  BE_W     = be_lanes(WR_W, FAMILY)
) (
    input  logic            wr_clk,
    input  logic            wr_srst,
    input  logic            wr_ce,
    input  logic            wr_en,
    input  logic            wr_stall,
    input  logic [WA_W-1:0] wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic [BE_W-1:0] wr_be,
    input  logic            rd_clk,
    input  logic            rd_clr,
    input  logic            rd_ce,
    input  logic            rd_en,
    input  logic            rd_stall,
    input  logic [RA_W-1:0] rd_addr,
    output logic [RD_W-1:0] rd_q
);
    logic [WA_W-1:0] wa_eff;
    logic [RA_W-1:0] ra_eff;
    logic [WR_W-1:0] wmask;
    logic            wr_go;
    logic            rd_go;

    assign wr_go = wr_ce & wr_en;
    assign rd_go = rd_ce & rd_en;

    mwram_addr_hold #(.AW(WA_W), .ASYNC_CLR(1'b0)) u_wr_hold (
        .clk(wr_clk), .clr(wr_srst), .ce(wr_ce), .stall(wr_stall),
        .a_in(wr_addr), .a_eff(wa_eff)
    );

    mwram_addr_hold #(.AW(RA_W), .ASYNC_CLR(1'b1)) u_rd_hold (
        .clk(rd_clk), .clr(rd_clr), .ce(rd_ce), .stall(rd_stall),
        .a_in(rd_addr), .a_eff(ra_eff)
    );

    mwram_lane_mask #(.FAMILY(FAMILY), .WR_W(WR_W)) u_mask (
        .go(wr_go), .be(wr_be), .mask(wmask)
    );

    mwram_array #(.MEM_BITS(MEM_BITS), .WR_W(WR_W), .RD_W(RD_W)) u_array (
        .wr_clk(wr_clk), .wr_addr(wa_eff), .wr_data(wr_data), .wr_mask(wmask),
        .rd_clk(rd_clk), .rd_clr(rd_clr), .rd_go(rd_go), .rd_addr(ra_eff),
        .rd_q(rd_q)
    );

endmodule

// File: tb/sim_mwram_top.sv
module sim_mwram_top;
    import mwram_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic        wr_srst = 1'b1, wr_ce = 1'b1, wr_en = 1'b0, wr_stall = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be   = 2'b11;
    logic        rd_clr = 1'b1, rd_ce = 1'b1, rd_en = 1'b0, rd_stall = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [7:0]  rd_q;

    logic        w1_en = 1'b0;
    logic [6:0]  w1_addr = '0;
    logic [35:0] w1_data = '0;
    logic [3:0]  w1_be = 4'hF;
    logic        r1_en = 1'b0;
    logic [7:0]  r1_addr = '0;
    logic [17:0] r1_q;

    mwram_top u0 (
        .wr_clk(clk), .wr_srst(wr_srst), .wr_ce(wr_ce), .wr_en(wr_en),
        .wr_stall(wr_stall), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_clk(clk), .rd_clr(rd_clr), .rd_ce(rd_ce), .rd_en(rd_en),
        .rd_stall(rd_stall), .rd_addr(rd_addr), .rd_q(rd_q)
    );

    mwram_top #(.FAMILY(FAM_PARITY), .WR_W(36), .RD_W(18)) u1 (
        .wr_clk(clk), .wr_srst(wr_srst), .wr_ce(wr_ce), .wr_en(w1_en),
        .wr_stall(1'b0), .wr_addr(w1_addr), .wr_data(w1_data), .wr_be(w1_be),
        .rd_clk(clk), .rd_clr(rd_clr), .rd_ce(rd_ce), .rd_en(r1_en),
        .rd_stall(1'b0), .rd_addr(r1_addr), .rd_q(r1_q)
    );

    typedef struct packed {
        logic [7:0]  wa;
        logic [15:0] wd;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'd0,   16'hA55A}, '{8'd1,   16'h0102}, '{8'd2,   16'hFFEE},
        '{8'd17,  16'h3C4D}, '{8'd100, 16'h8001}, '{8'd128, 16'h7F7F},
        '{8'd254, 16'h1357}, '{8'd255, 16'hC0DE}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr16(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd8(input logic [8:0] a);
        rd_en = 1'b1; rd_addr = a;
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        tick(); tick();
        chk("R10 reset output zero", 64'(rd_q), 64'h0);
        chk("R10 reset output zero u1", 64'(r1_q), 64'h0);
        wr_srst = 1'b0; rd_clr = 1'b0;

        // R1 / R2 / R4: vector table, including first and last words
        foreach (VECS[i]) wr16(VECS[i].wa, VECS[i].wd, 2'b11);
        foreach (VECS[i]) begin
            rd8({VECS[i].wa, 1'b0});
            chk("R2 R4 low byte", 64'(rd_q), 64'(VECS[i].wd[7:0]));
            rd8({VECS[i].wa, 1'b1});
            chk("R2 R1 high byte", 64'(rd_q), 64'(VECS[i].wd[15:8]));
        end

        // R6: lane enables
        wr16(8'd40, 16'hFFFF, 2'b11);
        wr16(8'd40, 16'h1234, 2'b10);
        rd8(9'd80);  chk("R6 masked low lane", 64'(rd_q), 64'hFF);
        rd8(9'd81);  chk("R6 enabled high lane", 64'(rd_q), 64'h12);
        wr16(8'd40, 16'h0000, 2'b00);
        rd8(9'd81);  chk("R6 no lanes enabled", 64'(rd_q), 64'h12);

        // R7: write stall
        wr16(8'd60, 16'h6060, 2'b11);
        wr16(8'd50, 16'h5050, 2'b11);
        wr_stall = 1'b1;
        wr16(8'd60, 16'hABCD, 2'b11);
        wr_stall = 1'b0;
        rd8(9'd100); chk("R7 stalled write landed", 64'(rd_q), 64'hCD);
        rd8(9'd121); chk("R7 new address untouched", 64'(rd_q), 64'h60);

        // R8: read stall
        rd8(9'd101); chk("R8 capture", 64'(rd_q), 64'hAB);
        rd_stall = 1'b1;
        rd8(9'd120); chk("R8 stalled read", 64'(rd_q), 64'hAB);
        rd_stall = 1'b0;

        // R9: write clock enable low
        wr_ce = 1'b0;
        wr16(8'd50, 16'h0000, 2'b11);
        wr_ce = 1'b1;
        rd8(9'd100); chk("R9 ce low no write", 64'(rd_q), 64'hCD);

        // R3: holds
        rd_addr = 9'd120; tick();
        chk("R3 read enable low holds", 64'(rd_q), 64'hCD);
        rd_ce = 1'b0;
        rd8(9'd121);
        chk("R3 read ce low holds", 64'(rd_q), 64'hCD);
        rd_ce = 1'b1;

        // R5: same-edge collision
        wr16(8'd70, 16'h1111, 2'b11);
        wr_en = 1'b1; wr_addr = 8'd70; wr_data = 16'h2222; wr_be = 2'b11;
        rd_en = 1'b1; rd_addr = 9'd140;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R5 old data on collision", 64'(rd_q), 64'h11);
        rd8(9'd140); chk("R5 new data later", 64'(rd_q), 64'h22);

        // R10: asynchronous clear
        rd_clr = 1'b1;
        #1;
        chk("R10 immediate clear", 64'(rd_q), 64'h0);
        tick();
        rd_clr = 1'b0;
        rd8(9'd140); chk("R10 contents kept", 64'(rd_q), 64'h22);
        rd_clr = 1'b1; tick(); rd_clr = 1'b0;
        rd_stall = 1'b1;
        rd8(9'd300); chk("R10 held read address zero", 64'(rd_q), 64'h5A);
        rd_stall = 1'b0;

        // R11: write-side reset of held address
        wr_srst = 1'b1; tick(); wr_srst = 1'b0;
        wr_stall = 1'b1;
        wr16(8'd99, 16'h7E7E, 2'b11);
        wr_stall = 1'b0;
        rd8(9'd0); chk("R11 stalled write to zero", 64'(rd_q), 64'h7E);

        // R1 / R2 / R6: parity family, 36-bit write, 18-bit read
        w1_en = 1'b1; w1_addr = 7'd5; w1_data = 36'hF_FFFF_FFFF; w1_be = 4'hF;
        tick();
        w1_data = 36'h9_8765_4321; w1_be = 4'b0101;
        tick();
        w1_addr = 7'd127; w1_data = 36'h1_2345_6789; w1_be = 4'hF;
        tick();
        w1_en = 1'b0;
        r1_en = 1'b1; r1_addr = 8'd10; tick();
        chk("R6 parity lanes low", 64'(r1_q), 64'({9'h1FF, 9'h121}));
        r1_addr = 8'd11; tick();
        chk("R6 parity lanes high", 64'(r1_q), 64'({9'h1FF, 9'h1D9}));
        r1_addr = 8'd255; tick();
        chk("R1 parity last word", 64'(r1_q), 64'(18'(36'h1_2345_6789 >> 18)));
        r1_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule